// File: doc/BRIEF.md
# Auto-Indexing Dual Address Port

This block gives a processor a narrow byte-wide window into a large video memory. The memory is reached through two independent 17-bit pointers, each paired with its own data port. Every access through a data port reads or writes the byte at that port's pointer and then moves the pointer by a programmed step, upward or downward. Software can therefore stream through memory with one register access per byte. Strided patterns such as columns, interleaved channels or tile rows need no address rewrites.

The three address registers and the step/direction field are shared by both pointers. A select bit in the control register chooses which pointer they show. Both data ports always use their own pointer, whatever the select bit holds.

Each port keeps a prefetched copy of the byte at its pointer, so a data-port read completes in one bus cycle. The copy is refreshed by a small state machine. The machine rests in `FS_IDLE`. Any register write, or any data-port read, moves it to `FS_FETCH0`, which reads the RAM at pointer 0. From there it goes to `FS_FETCH1`, which reads the RAM at pointer 1 and captures the result for port 0. It then moves to `FS_LOAD1`, which captures the result for port 1. From `FS_LOAD1` it returns to `FS_IDLE`, or goes straight back to `FS_FETCH0` if a new trigger arrives. Reset enters `FS_FETCH0`, so both copies are filled after reset.

The processor must leave at least four clock cycles between the start of one access and the start of the next. The memory array is a synchronous RAM of 2^MEM_AW bytes.

Top module: `dap_port_window`

## Requirements
- R1: Reset clears both pointers to address 0, step code 0 and upward direction, and clears the select bit. Offsets 0, 1, 2 and 5 then read 0. Offsets 6 and 7 always read 0, and writes to them have no effect.
- R2: Control register (offset 5) bit 0 selects the pointer that offsets 0 to 2 read and write (0 = pointer 0, 1 = pointer 1). Its other bits read as 0. Address writes leave the unselected pointer unchanged.
- R3: The high register (offset 2) has this layout: bit 0 is address bit 16, bit 3 selects downward stepping, and bits 7:4 hold the step code. Bits 2:1 are ignored and read as 0. Offset 0 holds address bits 7:0 and offset 1 holds bits 15:8.
- R4: Step codes 0 to 15 give the steps 0, 1, 2, 4, 8, 16, 32, 64, 128, 256, 512, 40, 80, 160, 320 and 640.
- R5: A write to a data port stores the byte at that port's pointer, then moves the pointer by its step.
- R6: A read of a data port returns the byte at that port's pointer, then moves the pointer. A read whose value is discarded still moves it.
- R7: Data port 0 is at offset 3 and uses pointer 0. Data port 1 is at offset 4 and uses pointer 1. Both hold whatever the select bit is.
- R8: With downward stepping set, the step is subtracted. Writing 0x38 to offset 2 gives a step of 4 downward and clears address bit 16.
- R9: Pointer arithmetic wraps modulo 2^17 in both directions.
- R10: Writing the high register changes address bit 16, direction and step, but leaves address bits 15:0 unchanged.
- R11: Once the access spacing has elapsed after any pointer change or memory write, a data-port read returns the current byte at its pointer. This includes a byte just written through the other port.
- R12: The RAM is indexed by the low MEM_AW pointer bits, so pointers that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| offset | input | 3 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read strobe |

## Verification
A pointer that has stepped wrongly, or that belongs to the wrong port, shows up at the very next address-register read. It also shows up one access later as a data byte from the wrong location. A stale prefetch copy appears only when that port is next read, so the bench reads each port right after a change made through the other port or through the address registers. A wrong select or step field reads back in the cycle after the read strobe. A fill state machine stuck outside its idle state leaves the copies stale, and the next data read exposes that.

// File: rtl/dap_pkg.sv
package dap_pkg;

    localparam int PTR_W  = 17;
    localparam int STEP_W = 10;

    localparam logic [2:0] OFS_ADDR_LO  = 3'd0;
    localparam logic [2:0] OFS_ADDR_MID = 3'd1;
    localparam logic [2:0] OFS_ADDR_HI  = 3'd2;
    localparam logic [2:0] OFS_PORT0    = 3'd3;
    localparam logic [2:0] OFS_PORT1    = 3'd4;
    localparam logic [2:0] OFS_CTRL     = 3'd5;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_FETCH0 = 2'd1,
        FS_FETCH1 = 2'd2,
        FS_LOAD1  = 2'd3
    } fill_state_e;

    function automatic logic [STEP_W-1:0] step_size(input logic [3:0] code);
        logic [STEP_W-1:0] s;
        if (code <= 4'd10) begin
            s = (code == 4'd0) ? '0 : (STEP_W'(1) << (code - 4'd1));
        end else begin
            s = STEP_W'(40) << (code - 4'd11);
        end
        return s;
    endfunction

endpackage

// File: rtl/dap_pointer.sv
module dap_pointer
    import dap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_mid,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    input  logic             advance,
    output logic [PTR_W-1:0] addr,
    output logic [3:0]       step_code,
    output logic             step_down
);

    logic [PTR_W-1:0] step_ext;

    always_comb begin
        step_ext = {{(PTR_W-STEP_W){1'b0}}, step_size(step_code)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            step_code <= '0;
            step_down <= 1'b0;
        end else if (wr_lo) begin
            addr[7:0] <= wdata;
        end else if (wr_mid) begin
            addr[15:8] <= wdata;
        end else if (wr_hi) begin
            addr[16]  <= wdata[0];
            step_down <= wdata[3];
            step_code <= wdata[7:4];
        end else if (advance) begin
            addr <= step_down ? (addr - step_ext) : (addr + step_ext);
        end
    end

endmodule

// File: rtl/dap_ram.sv
module dap_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/dap_fill_fsm.sv
module dap_fill_fsm
    import dap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output fill_state_e state,
    output logic        fetch_sel,
    output logic        load0,
    output logic        load1
);

    fill_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE:   if (start) state_nx = FS_FETCH0;
            FS_FETCH0: state_nx = FS_FETCH1;
            FS_FETCH1: state_nx = FS_LOAD1;
            FS_LOAD1:  state_nx = start ? FS_FETCH0 : FS_IDLE;
            default:   state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_FETCH0;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        fetch_sel = 1'b0;
        load0     = 1'b0;
        load1     = 1'b0;
        unique case (state)
            FS_IDLE:   ;
            FS_FETCH0: fetch_sel = 1'b0;
            FS_FETCH1: begin
                fetch_sel = 1'b1;
                load0     = 1'b1;
            end
            FS_LOAD1:  load1 = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/dap_port_window.sv
module dap_port_window
    import dap_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       we,
    input  logic [2:0] offset,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    localparam int NPORT = 2;

    logic                        sel;
    logic [NPORT-1:0][PTR_W-1:0] ptr_addr;
    logic [NPORT-1:0][3:0]       ptr_code;
    logic [NPORT-1:0]            ptr_down;
    logic [NPORT-1:0][7:0]       pre_data;

    logic        dp_hit;
    logic        dp_port;
    logic        bus_wr;
    logic        start;
    logic        ram_we;
    logic [MEM_AW-1:0] ram_addr;
    logic [7:0]  ram_q;
    fill_state_e fill_state;
    logic        fetch_sel;
    logic        load0;
    logic        load1;

    always_comb begin
        bus_wr  = cs && we;
        dp_hit  = cs && ((offset == OFS_PORT0) || (offset == OFS_PORT1));
        dp_port = (offset == OFS_PORT1);
        start   = bus_wr || dp_hit;
        ram_we  = dp_hit && we;
        ram_addr = ram_we ? ptr_addr[dp_port][MEM_AW-1:0]
                          : ptr_addr[fetch_sel][MEM_AW-1:0];
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_ptr
        logic mine;
        always_comb mine = (sel == 1'(g));
        dap_pointer u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (bus_wr && mine && (offset == OFS_ADDR_LO)),
            .wr_mid    (bus_wr && mine && (offset == OFS_ADDR_MID)),
            .wr_hi     (bus_wr && mine && (offset == OFS_ADDR_HI)),
            .wdata     (wdata),
            .advance   (dp_hit && (dp_port == 1'(g))),
            .addr      (ptr_addr[g]),
            .step_code (ptr_code[g]),
            .step_down (ptr_down[g])
        );
    end

    dap_ram #(.AW(MEM_AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (wdata),
        .rdata (ram_q)
    );

    dap_fill_fsm u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .state     (fill_state),
        .fetch_sel (fetch_sel),
        .load0     (load0),
        .load1     (load1)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= 1'b0;
        end else if (bus_wr && (offset == OFS_CTRL)) begin
            sel <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_data <= '0;
        end else begin
            if (load0) pre_data[0] <= ram_q;
            if (load1) pre_data[1] <= ram_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cs && !we) begin
            unique case (offset)
                OFS_ADDR_LO:  rdata <= ptr_addr[sel][7:0];
                OFS_ADDR_MID: rdata <= ptr_addr[sel][15:8];
                OFS_ADDR_HI:  rdata <= {ptr_code[sel], ptr_down[sel], 2'b00, ptr_addr[sel][16]};
                OFS_PORT0:    rdata <= pre_data[0];
                OFS_PORT1:    rdata <= pre_data[1];
                OFS_CTRL:     rdata <= {7'b0, sel};
                default:      rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/dap_port_window_chk.sv
module dap_port_window_chk
    import dap_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs,
    input logic                   we,
    input logic [2:0]             offset,
    input logic [7:0]             rdata,
    input logic                   sel,
    input logic [1:0][PTR_W-1:0]  ptr_addr,
    input logic [1:0][3:0]        ptr_code,
    input logic [1:0]             ptr_down,
    input fill_state_e            fill_state
);

    logic addr_wr;
    logic [PTR_W-1:0] step0;
    always_comb begin
        addr_wr = cs && we && (offset <= OFS_ADDR_HI);
        step0   = {{(PTR_W-STEP_W){1'b0}}, step_size(ptr_code[0])};
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (ptr_addr == '0) && !sel && (fill_state == FS_FETCH0));

    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && offset == OFS_CTRL) |=> (rdata[7:1] == 7'd0));

    p_unsel_hold0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && sel) |=> $stable(ptr_addr[0]));

    p_unsel_hold1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !sel) |=> $stable(ptr_addr[1]));

    p_hi_keeps_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && offset == OFS_ADDR_HI && !sel) |=> $stable(ptr_addr[0][15:0]));

    p_port0_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && offset == OFS_PORT0) |=>
        ptr_addr[0] == ($past(ptr_down[0]) ? $past(ptr_addr[0]) - $past(step0)
                                           : $past(ptr_addr[0]) + $past(step0)));

    p_port1_leaves_ptr0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && offset == OFS_PORT1) |=> $stable(ptr_addr[0]));

    p_refill_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (we || offset == OFS_PORT0 || offset == OFS_PORT1)) |=> (fill_state == FS_FETCH0));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(ptr_addr));

endmodule

bind dap_port_window dap_port_window_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .we         (we),
    .offset     (offset),
    .rdata      (rdata),
    .sel        (sel),
    .ptr_addr   (ptr_addr),
    .ptr_code   (ptr_code),
    .ptr_down   (ptr_down),
    .fill_state (fill_state)
);

// File: tb/dap_port_window_bench.sv
module dap_port_window_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [2:0] offset = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dap_port_window u_dap_port_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .we     (we),
        .offset (offset),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    // vector: {op[1:0], offset[2:0], data[7:0], req[3:0]}
    // op 0 = write data, 1 = read and compare with data, 2 = read and discard
    function automatic logic [16:0] vv(input logic [1:0] op, input logic [2:0] ofs,
                                       input logic [7:0] d, input logic [3:0] req);
        return {op, ofs, d, req};
    endfunction

    localparam int NV = 68;
    localparam logic [16:0] VEC [NV] = '{
        vv(0,0,8'h10,5), vv(0,1,8'h00,5), vv(0,2,8'h10,3),        // R5 R3 pointer0=0x10 step 1 up
        vv(0,3,8'hA1,5), vv(0,3,8'hA2,5), vv(1,0,8'h12,5),        // R5 write then advance
        vv(1,2,8'h10,3),                                          // R3 layout
        vv(0,0,8'h10,11), vv(1,3,8'hA1,11), vv(1,3,8'hA2,6),      // R11 R6 prefetch after rewrite
        vv(1,0,8'h12,6), vv(2,3,8'h00,6), vv(1,0,8'h13,6),        // R6 discarded read moves
        vv(0,2,8'h38,10), vv(1,0,8'h13,10), vv(1,2,8'h38,3),      // R10 step change keeps address
        vv(0,3,8'hB0,8), vv(1,0,8'h0F,8),                         // R8 step 4 downward
        vv(0,0,8'h02,9), vv(2,3,8'h00,9), vv(1,0,8'hFE,9),        // R9 wrap below zero
        vv(1,1,8'hFF,9), vv(1,2,8'h39,9),
        vv(0,2,8'h11,9), vv(0,3,8'hC1,9), vv(0,3,8'hC2,9),        // R9 wrap above top
        vv(1,0,8'h00,9), vv(1,1,8'h00,9), vv(1,2,8'h10,9),
        vv(0,0,8'hFE,12), vv(0,1,8'h0F,12),                       // R12 alias of 0x7FE
        vv(1,3,8'hC1,12), vv(1,3,8'hC2,12),
        vv(0,2,8'hB0,4), vv(0,0,8'h00,4), vv(0,1,8'h00,4),        // R4 code 11 = 40
        vv(2,3,8'h00,4), vv(1,0,8'h28,4),
        vv(0,2,8'hF0,4), vv(2,3,8'h00,4), vv(1,0,8'hA8,4),        // R4 code 15 = 640
        vv(1,1,8'h02,4),
        vv(0,2,8'h90,4), vv(2,3,8'h00,4), vv(1,1,8'h03,4),        // R4 code 9 = 256
        vv(0,2,8'h00,4), vv(2,3,8'h00,4), vv(1,0,8'hA8,4),        // R4 code 0 = no move
        vv(1,1,8'h03,4),
        vv(0,5,8'hFF,2), vv(1,5,8'h01,2), vv(1,0,8'h00,2),        // R2 select pointer 1
        vv(0,0,8'h10,7), vv(0,2,8'h10,7), vv(1,4,8'hA1,7),        // R7 port 1 own pointer
        vv(1,0,8'h11,7),
        vv(0,5,8'h00,2), vv(1,0,8'hA8,2),                         // R2 pointer 0 untouched
        vv(0,0,8'h11,11), vv(0,1,8'h00,11), vv(0,2,8'h10,11),     // R11 pointer0=0x11
        vv(0,4,8'hD4,7), vv(1,3,8'hD4,11),                        // R7 R11 cross-port refresh
        vv(0,2,8'h17,3), vv(1,2,8'h11,3),                         // R3 bits 2:1 dropped
        vv(1,6,8'h00,1), vv(0,7,8'h5A,1), vv(1,7,8'h00,1)         // R1 unused offsets
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; offset = ofs; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [2:0] ofs, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; offset = ofs;
        @(negedge clk);
        d = rdata;
        cs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic reset_checks();
        logic [7:0] r;
        check(1, rdata, 8'h00);                 // R1 read register cleared
        bus_rd(3'd0, r); check(1, r, 8'h00);    // R1
        bus_rd(3'd1, r); check(1, r, 8'h00);    // R1
        bus_rd(3'd2, r); check(1, r, 8'h00);    // R1
        bus_rd(3'd5, r); check(1, r, 8'h00);    // R1
    endtask

    initial begin
        logic [7:0] r;
        do_reset();
        reset_checks();

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [2:0] ofs;
            logic [7:0] d;
            logic [3:0] req;
            {op, ofs, d, req} = VEC[i];
            if (op == 2'd0) begin
                bus_wr(ofs, d);
            end else begin
                bus_rd(ofs, r);
                if (op == 2'd1) check(int'(req), r, d);
            end
        end

        // R1: reset mid-run after pointers, select and steps were changed
        bus_wr(3'd5, 8'h01);
        bus_wr(3'd2, 8'hF9);
        do_reset();
        reset_checks();
        bus_wr(3'd5, 8'h01);
        bus_rd(3'd2, r); check(1, r, 8'h00);    // R1 pointer 1 also cleared

        // R6 R12: discarded read on port 1 with step 1 wraps pointer through 0x7FF alias
        bus_wr(3'd0, 8'hFF); bus_wr(3'd1, 8'h0F); bus_wr(3'd2, 8'h10);
        bus_wr(3'd4, 8'h5C);                    // stores at 0x00FFF -> RAM 0x7FF
        bus_wr(3'd0, 8'hFF); bus_wr(3'd1, 8'h07);
        bus_rd(3'd4, r); check(12, r, 8'h5C);   // R12 same byte via 0x007FF
        bus_rd(3'd0, r); check(6, r, 8'h00);    // R6 advanced to 0x00800

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule